// File: doc/BRIEF.md
# Auto-Wakeup Halt Power Sequencer

This block sequences a small processor core into and out of a low-power halt with timed wakeup. When the core executes a halt instruction, the block checks the auto-wakeup enable, the active-halt selection and the watchdog. It then either parks the core with only the slow wakeup RC oscillator running, or raises a one-cycle watchdog reset instead of halting.

Wakeup comes from a reset request or from an interrupt line marked wake-capable by a parameter. Other interrupt lines are ignored while halted. Exit happens in two stages. The main oscillator and CPU clock return first, while the peripheral clocks stay gated for a 64-cycle settling window. After that window the peripherals are released. The core is then told, by a one-cycle pulse, either to fetch the reset vector or to service the waking interrupt.

When an interrupt is serviced, the block requests a push of the condition-code register and loads the two interrupt-mask bits with that interrupt's priority, captured at wake time. It restores the previous mask on a pop. Peripherals that run from an external clock keep their own gate, and that gate stays on at all times.

Top module: `awu_halt_seq`

## Requirements
- R1: A one-cycle `halt_req_i` with `awu_en_i`=1 and `act_halt_sel_i`=0 enters halt at the next clock edge, provided `wdg_en_i`=0 or `wdg_halt_opt_i`=1.
- R2: A halt request that meets R1's enable conditions, while `wdg_en_i`=1 and `wdg_halt_opt_i`=0, does not enter halt. It produces `wdg_rst_o`=1 for exactly one cycle, starting at the next clock edge.
- R3: A halt request with `awu_en_i`=0 or `act_halt_sel_i`=1 is ignored: there is no halt and no watchdog reset.
- R4: While halted: `rc_osc_en_o`=1 and `main_osc_en_o`=`periph_clk_en_o`=`cpu_clk_en_o`=0. `ext_periph_clk_en_o` is 1 in every state.
- R5: Entering halt forces `imask_o` to 2'b10.
- R6: While halted, only `wake_rst_i` or a line i of `wake_irq_i` with `WAKE_SRC_MASK[i]`=1 (default 8'h03, lines 0 and 1) ends halt. Other lines have no effect.
- R7: After a wake, the block spends exactly 64 cycles in recovery. During recovery `rc_osc_en_o`=0, `main_osc_en_o`=`cpu_clk_en_o`=1, `periph_clk_en_o`=0, and `imask_o` is unchanged.
- R8: In the first cycle after recovery, every clock enable except `rc_osc_en_o` is 1. In that cycle `fetch_rst_vec_o` pulses for one cycle if the wake cause was reset. Otherwise `service_irq_o` and `cc_push_o` pulse for one cycle. The cause is latched at wake time, even if the request drops afterwards.
- R9: If `wake_rst_i` and a wake-capable interrupt are both present at wake time, reset is taken as the cause.
- R10: When an interrupt is serviced, `imask_o` takes the value of `irq_prio_i` sampled at wake time. A `pop_i` pulse restores the mask that was held before the service.
- R11: Synchronous reset `rst` gives the run state: `rc_osc_en_o`=0, the main, CPU and peripheral enables at 1, `imask_o`=2'b11, and all pulse outputs at 0.
- R12: `halt_req_i` and `wake_rst_i` have no effect during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock domain clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| halt_req_i | input | 1 | One-cycle pulse when a halt instruction executes |
| awu_en_i | input | 1 | Auto-wakeup enable bit |
| act_halt_sel_i | input | 1 | Active-halt variant selected; must be 0 for this halt |
| wdg_en_i | input | 1 | Watchdog running |
| wdg_halt_opt_i | input | 1 | Option bit: 1 lets halt proceed with the watchdog running |
| wake_rst_i | input | 1 | Reset request that ends halt |
| wake_irq_i | input | NUM_IRQ | Pending interrupt lines |
| irq_prio_i | input | 2 | Software priority of the waking interrupt |
| pop_i | input | 1 | Condition-code register popped |
| rc_osc_en_o | output | 1 | Wakeup RC oscillator enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| periph_clk_en_o | output | 1 | Internal peripheral clock gate |
| ext_periph_clk_en_o | output | 1 | Gate for externally clocked peripherals |
| cpu_clk_en_o | output | 1 | CPU clock gate |
| imask_o | output | 2 | Interrupt-mask bits |
| wdg_rst_o | output | 1 | Watchdog reset pulse in place of halt |
| fetch_rst_vec_o | output | 1 | Pulse: fetch the reset vector |
| service_irq_o | output | 1 | Pulse: service the waking interrupt |
| cc_push_o | output | 1 | Pulse: push the condition-code register |

## Verification
The halt entry decision is tried over a table of enable and watchdog combinations. Each row tells apart the three outcomes: a halt, a watchdog reset, or an ignored request. Wakeup is tried with a non-wake-capable line (no exit), a wake-capable line whose priority changes during recovery (this tests the capture at wake time), and reset together with an interrupt (this tests the cause priority). A stray halt request and a stray reset request are injected in the middle of recovery. This shows that neither the 64-cycle length nor the latched cause moves.

// File: rtl/awu_pkg.sv
package awu_pkg;

    localparam int PRIO_W = 2;

    localparam logic [PRIO_W-1:0] MASK_AT_RESET = 2'b11;
    localparam logic [PRIO_W-1:0] MASK_IN_HALT  = 2'b10;

    typedef enum logic [1:0] {
        PS_RUN,
        PS_HALT,
        PS_RECOVER
    } pwr_state_e;

    typedef enum logic {
        WC_IRQ,
        WC_RST
    } wake_cause_e;

    typedef struct packed {
        logic rc;
        logic main;
        logic periph;
        logic cpu;
    } clk_gate_t;

    function automatic clk_gate_t gates_for(input pwr_state_e s);
        clk_gate_t g;
        case (s)
            PS_HALT:    g = '{rc: 1'b1, main: 1'b0, periph: 1'b0, cpu: 1'b0};
            PS_RECOVER: g = '{rc: 1'b0, main: 1'b1, periph: 1'b0, cpu: 1'b1};
            default:    g = '{rc: 1'b0, main: 1'b1, periph: 1'b1, cpu: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/awu_entry_ctrl.sv
module awu_entry_ctrl
    import awu_pkg::*;
(
    input  logic halt_req,
    input  logic awu_en,
    input  logic act_halt_sel,
    input  logic wdg_en,
    input  logic wdg_halt_opt,
    input  logic in_run,
    output logic go_halt,
    output logic wdg_trip
);
    logic eligible;
    logic wdg_blocks;

    always_comb begin
        eligible   = in_run && halt_req && awu_en && !act_halt_sel;
        wdg_blocks = wdg_en && !wdg_halt_opt;
        go_halt    = eligible && !wdg_blocks;
        wdg_trip   = eligible && wdg_blocks;
    end
endmodule

// File: rtl/awu_settle_timer.sv
module awu_settle_timer
    import awu_pkg::*;
#(
    parameter int DELAY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int W = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [W-1:0] TOP = W'(DELAY - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TOP;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R7
    load_top_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == TOP));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/awu_mask_ctrl.sv
module awu_mask_ctrl
    import awu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_halt,
    input  logic              service,
    input  logic [PRIO_W-1:0] prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] imask
);
    logic [PRIO_W-1:0] mask_q;
    logic [PRIO_W-1:0] saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= MASK_AT_RESET;
            saved_q <= MASK_AT_RESET;
        end else if (enter_halt) begin
            mask_q <= MASK_IN_HALT;
        end else if (service) begin
            saved_q <= mask_q;
            mask_q  <= prio;
        end else if (pop) begin
            mask_q <= saved_q;
        end
    end

    assign imask = mask_q;

    // R5
    halt_mask_chk: assert property (@(posedge clk) disable iff (rst)
        enter_halt |=> (imask == MASK_IN_HALT));

    // R10
    svc_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (service && !enter_halt) |=> (imask == $past(prio)));
endmodule

// File: rtl/awu_halt_seq.sv
module awu_halt_seq
    import awu_pkg::*;
#(
    parameter int                NUM_IRQ       = 8,
    parameter logic [NUM_IRQ-1:0] WAKE_SRC_MASK = 8'h03,
    parameter int                SETTLE_CYC    = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req_i,
    input  logic               awu_en_i,
    input  logic               act_halt_sel_i,
    input  logic               wdg_en_i,
    input  logic               wdg_halt_opt_i,
    input  logic               wake_rst_i,
    input  logic [NUM_IRQ-1:0] wake_irq_i,
    input  logic [PRIO_W-1:0]  irq_prio_i,
    input  logic               pop_i,
    output logic               rc_osc_en_o,
    output logic               main_osc_en_o,
    output logic               periph_clk_en_o,
    output logic               ext_periph_clk_en_o,
    output logic               cpu_clk_en_o,
    output logic [PRIO_W-1:0]  imask_o,
    output logic               wdg_rst_o,
    output logic               fetch_rst_vec_o,
    output logic               service_irq_o,
    output logic               cc_push_o
);
    pwr_state_e        st_q, st_d;
    wake_cause_e       cause_q;
    logic [PRIO_W-1:0] prio_q;
    logic              wdg_q, fetch_q, svc_q;

    logic go_halt, wdg_trip;
    logic irq_wake, any_wake, leave_rec, expired;
    clk_gate_t gate;

    awu_entry_ctrl u_entry (
        .halt_req     (halt_req_i),
        .awu_en       (awu_en_i),
        .act_halt_sel (act_halt_sel_i),
        .wdg_en       (wdg_en_i),
        .wdg_halt_opt (wdg_halt_opt_i),
        .in_run       (st_q == PS_RUN),
        .go_halt      (go_halt),
        .wdg_trip     (wdg_trip)
    );

    awu_settle_timer #(.DELAY(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (st_q == PS_HALT && any_wake),
        .run     (st_q == PS_RECOVER),
        .expired (expired)
    );

    always_comb begin
        irq_wake  = |(wake_irq_i & WAKE_SRC_MASK);
        any_wake  = wake_rst_i || irq_wake;
        leave_rec = (st_q == PS_RECOVER) && expired;
        st_d      = st_q;
        case (st_q)
            PS_RUN:     if (go_halt)  st_d = PS_HALT;
            PS_HALT:    if (any_wake) st_d = PS_RECOVER;
            PS_RECOVER: if (expired)  st_d = PS_RUN;
            default:    st_d = PS_RUN;
        endcase
    end

    awu_mask_ctrl u_mask (
        .clk        (clk),
        .rst        (rst),
        .enter_halt (go_halt),
        .service    (leave_rec && cause_q == WC_IRQ),
        .prio       (prio_q),
        .pop        (pop_i),
        .imask      (imask_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= PS_RUN;
            cause_q <= WC_IRQ;
            prio_q  <= '0;
            wdg_q   <= 1'b0;
            fetch_q <= 1'b0;
            svc_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            wdg_q   <= wdg_trip;
            fetch_q <= leave_rec && cause_q == WC_RST;
            svc_q   <= leave_rec && cause_q == WC_IRQ;
            if (st_q == PS_HALT && any_wake) begin
                cause_q <= wake_rst_i ? WC_RST : WC_IRQ;
                prio_q  <= irq_prio_i;
            end
        end
    end

    assign gate                = gates_for(st_q);
    assign rc_osc_en_o         = gate.rc;
    assign main_osc_en_o       = gate.main;
    assign periph_clk_en_o     = gate.periph;
    assign cpu_clk_en_o        = gate.cpu;
    assign ext_periph_clk_en_o = 1'b1;
    assign wdg_rst_o           = wdg_q;
    assign fetch_rst_vec_o     = fetch_q;
    assign service_irq_o       = svc_q;
    assign cc_push_o           = svc_q;

    logic [15:0] rec_len_q;
    always_ff @(posedge clk) begin
        if (rst)                    rec_len_q <= '0;
        else if (st_q == PS_RECOVER) rec_len_q <= rec_len_q + 1'b1;
        else                         rec_len_q <= '0;
    end

    // R7
    rec_len_chk: assert property (@(posedge clk) disable iff (rst)
        leave_rec |-> (rec_len_q == 16'(SETTLE_CYC - 1)));

    // R8
    periph_order_chk: assert property (@(posedge clk) disable iff (rst)
        periph_clk_en_o |-> (main_osc_en_o && cpu_clk_en_o));

    // R8
    exit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_rst_vec_o && service_irq_o));

    // R6
    halt_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_HALT && !any_wake) |=> (st_q == PS_HALT));

    // R2
    wdg_no_halt_chk: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_o |-> (st_q == PS_RUN));
endmodule

// File: tb/awu_halt_seq_tb_top.sv
`timescale 1ns/1ps
module awu_halt_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_req_i = 0, awu_en_i = 0, act_halt_sel_i = 0;
    logic       wdg_en_i = 0, wdg_halt_opt_i = 0, wake_rst_i = 0, pop_i = 0;
    logic [7:0] wake_irq_i = '0;
    logic [1:0] irq_prio_i = '0;
    logic       rc_osc_en_o, main_osc_en_o, periph_clk_en_o, ext_periph_clk_en_o;
    logic       cpu_clk_en_o, wdg_rst_o, fetch_rst_vec_o, service_irq_o, cc_push_o;
    logic [1:0] imask_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    awu_halt_seq dut_i (
        .clk(clk), .rst(rst), .halt_req_i(halt_req_i), .awu_en_i(awu_en_i),
        .act_halt_sel_i(act_halt_sel_i), .wdg_en_i(wdg_en_i),
        .wdg_halt_opt_i(wdg_halt_opt_i), .wake_rst_i(wake_rst_i),
        .wake_irq_i(wake_irq_i), .irq_prio_i(irq_prio_i), .pop_i(pop_i),
        .rc_osc_en_o(rc_osc_en_o), .main_osc_en_o(main_osc_en_o),
        .periph_clk_en_o(periph_clk_en_o), .ext_periph_clk_en_o(ext_periph_clk_en_o),
        .cpu_clk_en_o(cpu_clk_en_o), .imask_o(imask_o), .wdg_rst_o(wdg_rst_o),
        .fetch_rst_vec_o(fetch_rst_vec_o), .service_irq_o(service_irq_o),
        .cc_push_o(cc_push_o)
    );

    // {awu_en, act_halt_sel, wdg_en, wdg_halt_opt, outcome}; outcome 0 ignore, 1 halt, 2 watchdog reset
    localparam logic [5:0] ENTRY_TBL [8] = '{
        {4'b1000, 2'd1}, {4'b1011, 2'd1}, {4'b1010, 2'd2}, {4'b1001, 2'd1},
        {4'b0000, 2'd0}, {4'b0010, 2'd0}, {4'b1100, 2'd0}, {4'b1110, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        halt_req_i = 0; wake_rst_i = 0; wake_irq_i = '0; pop_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter_halt();
        awu_en_i = 1; act_halt_sel_i = 0; wdg_en_i = 0; wdg_halt_opt_i = 0;
        halt_req_i = 1;
        @(negedge clk);
        halt_req_i = 0;
    endtask

    // counts cycles spent in recovery; optionally injects stray requests at cycle 10
    task automatic run_recovery(input bit inject, output int n);
        n = 0;
        while (cpu_clk_en_o && !periph_clk_en_o && n < 200) begin
            n++;
            halt_req_i = inject && (n == 10);
            wake_rst_i = inject && (n == 10);
            if (rc_osc_en_o !== 1'b0 || main_osc_en_o !== 1'b1)
                chk(1'b0, "R7 recovery oscillators", {rc_osc_en_o, main_osc_en_o}, 2'b01);
            @(negedge clk);
        end
        halt_req_i = 0;
        wake_rst_i = 0;
    endtask

    initial begin
        int n;
        do_reset();
        // R11 reset state
        chk(rc_osc_en_o == 0 && main_osc_en_o && cpu_clk_en_o && periph_clk_en_o,
            "R11 clocks", {rc_osc_en_o, main_osc_en_o, periph_clk_en_o, cpu_clk_en_o}, 4'b0111);
        chk(imask_o == 2'b11, "R11 imask", imask_o, 2'b11);
        chk(!wdg_rst_o && !fetch_rst_vec_o && !service_irq_o && !cc_push_o, "R11 pulses",
            {wdg_rst_o, fetch_rst_vec_o, service_irq_o, cc_push_o}, 0);

        // R1 R2 R3 entry decision table
        foreach (ENTRY_TBL[i]) begin
            do_reset();
            {awu_en_i, act_halt_sel_i, wdg_en_i, wdg_halt_opt_i} = ENTRY_TBL[i][5:2];
            halt_req_i = 1;
            @(negedge clk);
            halt_req_i = 0;
            case (ENTRY_TBL[i][1:0])
                2'd1: chk(!cpu_clk_en_o && rc_osc_en_o && !wdg_rst_o, "R1 halt entry",
                          {cpu_clk_en_o, rc_osc_en_o, wdg_rst_o}, 3'b010);
                2'd2: chk(cpu_clk_en_o && !rc_osc_en_o && wdg_rst_o, "R2 watchdog reset",
                          {cpu_clk_en_o, rc_osc_en_o, wdg_rst_o}, 3'b101);
                default: chk(cpu_clk_en_o && !rc_osc_en_o && !wdg_rst_o, "R3 ignored",
                          {cpu_clk_en_o, rc_osc_en_o, wdg_rst_o}, 3'b100);
            endcase
            if (ENTRY_TBL[i][1:0] == 2'd2) begin
                @(negedge clk);
                chk(!wdg_rst_o && cpu_clk_en_o, "R2 one-cycle pulse", wdg_rst_o, 0);
            end
        end

        // R4 R5 halted state
        do_reset();
        enter_halt();
        chk(rc_osc_en_o && !main_osc_en_o && !periph_clk_en_o && !cpu_clk_en_o && ext_periph_clk_en_o,
            "R4 halt clocks",
            {rc_osc_en_o, main_osc_en_o, periph_clk_en_o, cpu_clk_en_o, ext_periph_clk_en_o}, 5'b10001);
        chk(imask_o == 2'b10, "R5 halt mask", imask_o, 2'b10);

        // R6 non-wake line ignored
        wake_irq_i = 8'h20;
        @(negedge clk);
        wake_irq_i = '0;
        @(negedge clk);
        chk(!cpu_clk_en_o && rc_osc_en_o, "R6 line 5 ignored", cpu_clk_en_o, 0);

        // R6 R7 R8 R10 R12 interrupt wake, stray requests in recovery
        wake_irq_i = 8'h02; irq_prio_i = 2'b01;
        @(negedge clk);
        wake_irq_i = '0; irq_prio_i = 2'b11;
        chk(cpu_clk_en_o && main_osc_en_o && !periph_clk_en_o && !rc_osc_en_o, "R7 recovery gates",
            {rc_osc_en_o, main_osc_en_o, periph_clk_en_o, cpu_clk_en_o}, 4'b0101);
        chk(imask_o == 2'b10, "R7 mask unchanged", imask_o, 2'b10);
        run_recovery(1'b1, n);
        chk(n == 64, "R7 R12 recovery length", n, 64);
        chk(periph_clk_en_o && main_osc_en_o && cpu_clk_en_o && !rc_osc_en_o, "R8 all running",
            {rc_osc_en_o, main_osc_en_o, periph_clk_en_o, cpu_clk_en_o}, 4'b0111);
        chk(service_irq_o && cc_push_o && !fetch_rst_vec_o, "R8 R12 service irq",
            {fetch_rst_vec_o, service_irq_o, cc_push_o}, 3'b011);
        chk(imask_o == 2'b01, "R10 prio loaded", imask_o, 2'b01);
        @(negedge clk);
        chk(!service_irq_o && !cc_push_o, "R8 pulse width", {service_irq_o, cc_push_o}, 0);
        pop_i = 1;
        @(negedge clk);
        pop_i = 0;
        chk(imask_o == 2'b10, "R10 pop restore", imask_o, 2'b10);

        // R8 R9 reset and irq together, both drop at once
        enter_halt();
        wake_rst_i = 1; wake_irq_i = 8'h01;
        @(negedge clk);
        wake_rst_i = 0; wake_irq_i = '0;
        run_recovery(1'b0, n);
        chk(n == 64, "R7 recovery length reset cause", n, 64);
        chk(fetch_rst_vec_o && !service_irq_o && !cc_push_o, "R9 reset wins",
            {fetch_rst_vec_o, service_irq_o, cc_push_o}, 3'b100);
        chk(imask_o == 2'b10, "R8 mask untouched on reset cause", imask_o, 2'b10);
        @(negedge clk);
        chk(!fetch_rst_vec_o, "R8 fetch pulse width", fetch_rst_vec_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule